// File: doc/BRIEF.md
# ISA memory card address decoder

This block decodes memory cycles for an 8-bit PC expansion card that carries one 512 KB SRAM and an optional 32 KB option ROM. It takes the 20-bit bus address, the active-low memory read and write strobes, the DMA address-enable line and a set of configuration straps. From these it drives the SRAM chip select, the remapped SRAM address, the SRAM output and write enables, the ROM chip select and address, and the enable and direction of the data-bus transceiver.

The lower 384 KB of the address space goes straight to the SRAM. Upper-memory windows between C0000h and EFFFFh are folded into the 128 KB of SRAM that base memory leaves free, at SRAM 60000h–7FFFFh. The C-page is split into two 32 KB halves. The D and E pages are handled as whole 64 KB pages. A layout strap decides which halves and pages hold RAM, which hold ROM and which stay unclaimed. An upper-enable strap turns off every upper window.

Top module: `isa_memdec_top`

## Requirements
- R1: Any bus address from 00000h to 5FFFFh selects the SRAM on a claimed cycle, for every strap setting, and the SRAM address equals the bus address.
- R2: Addresses 60000h–BFFFFh and F0000h–FFFFFh are never claimed by either device.
- R3: With `cfgUpperEn`=1 and `cfgLayout`=0, C0000h–DFFFFh is RAM and maps to SRAM address bus−60000h. C0000h lands on 60000h and D0000h on 70000h. E0000h–EFFFFh is unclaimed.
- R4: With `cfgLayout`=1, C8000h–DFFFFh is RAM with the same mapping as R3. C0000h–C7FFFh and the E page are unclaimed.
- R5: With `cfgLayout`=2, C8000h–CFFFFh is ROM. D0000h–DFFFFh is RAM at SRAM 70000h–7FFFFh, and E0000h–EFFFFh is RAM at SRAM 60000h–6FFFFh. C0000h–C7FFFh is unclaimed.
- R6: With `cfgLayout`=3, C0000h–C7FFFh is ROM and C8000h–DFFFFh is RAM with the R3 mapping. The E page is unclaimed.
- R7: With `cfgLayout`=4, C8000h–CFFFFh is ROM and D0000h–DFFFFh is RAM with the R3 mapping. C0000h–C7FFFh and the E page are unclaimed.
- R8: With `cfgUpperEn`=0, or with `cfgLayout` set to 5, 6 or 7, nothing above 5FFFFh is claimed.
- R9: A cycle is claimed only when `aen`=0 and at least one of `memrN`/`memwN` is 0. On any other cycle `sramCsN`, `sramOeN`, `sramWeN`, `romCsN` and `xcvrEnN` are all 1 and `xcvrToBus` is 0.
- R10: `romCsN` goes to 0 only on a read of a ROM window, and then `romAddr` equals bus address bits 14:0. A write to a ROM window claims nothing: all selects stay 1 and the transceiver stays off.
- R11: On a claimed SRAM cycle, a read drives `sramOeN`=0 and a write drives `sramWeN`=0. When both strobes are 0 the cycle counts as a read only.
- R12: `xcvrEnN` is 0 exactly when a device is claimed. `xcvrToBus` is 1 only on a claimed read and is 0 on claimed writes.
- R13: Within any one strap setting, no two distinct bus addresses reach the same SRAM location. In particular, an upper window never lands below SRAM 60000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| memAddr | input | 20 | Bus memory address |
| memrN | input | 1 | Memory read strobe, active low |
| memwN | input | 1 | Memory write strobe, active low |
| aen | input | 1 | DMA address enable; 1 means the cycle is not for this card |
| cfgUpperEn | input | 1 | Strap: 1 enables the upper windows |
| cfgLayout | input | 3 | Strap: upper-memory layout code 0–4, where 5–7 claim nothing |
| sramCsN | output | 1 | SRAM chip select, active low |
| sramAddr | output | 19 | SRAM address after remapping |
| sramOeN | output | 1 | SRAM output enable, active low |
| sramWeN | output | 1 | SRAM write enable, active low |
| romCsN | output | 1 | ROM chip select, active low |
| romAddr | output | 15 | ROM address |
| xcvrEnN | output | 1 | Data transceiver enable, active low |
| xcvrToBus | output | 1 | Transceiver direction, 1 = card drives the bus |

## Verification
The bench sweeps every 8 KB granule of the address space under all sixteen strap settings, using granule edges and random offsets. It tries reads, writes, both strobes together, no strobe, and address-enable cycles against a behavioural model.

The sweep targets several specific faults:
- A decode that ignores the top address bits mirrors 40000h–5FFFFh into the C and D pages. It is caught by the SRAM-location ownership check and by the unclaimed-hole comparisons.
- Flipping bit 17 on the E page as well would drop E0000h onto base memory.
- A ROM select that does not require a read would turn a ROM-window write into a claimed cycle.
- A transceiver that ignores the cycle direction would fight the bus on writes.
- Mistakes at 32 KB resolution, such as swapping the two C-page halves, show up at C7FFFh and C8000h.

// File: rtl/isa_memdec_pkg.sv
package isa_memdec_pkg;

  localparam int ISA_AW = 20;
  localparam int SLOT_N = 4;   // C low half, C high half, D page, E page

  typedef enum logic [2:0] {
    LAY_FULL128     = 3'd0,
    LAY_TRIM96      = 3'd1,
    LAY_ROMC8_RAM128 = 3'd2,
    LAY_ROMC0_RAM96 = 3'd3,
    LAY_ROMC8_RAM64 = 3'd4
  } lay_e;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_RAM  = 2'd1,
    OWN_ROM  = 2'd2
  } slot_owner_e;

  // strobes passed from region decode to the datapath
  typedef struct packed {
    logic ramSel;
    logic romSel;
    logic rdCyc;
    logic wrCyc;
    logic flipBit17;
  } dec_strobe_t;

  function automatic logic [ISA_AW-1:0] slotBase(input int s);
    case (s)
      0:       return 20'hC0000;
      1:       return 20'hC8000;
      2:       return 20'hD0000;
      default: return 20'hE0000;
    endcase
  endfunction

  // number of low address bits inside a slot
  function automatic int slotSpan(input int s);
    return (s < 2) ? 15 : 16;
  endfunction

  function automatic slot_owner_e slotOwner(input logic [2:0] lay, input int s);
    slot_owner_e own;
    own = OWN_NONE;
    case (lay)
      LAY_FULL128:      own = (s <= 2) ? OWN_RAM : OWN_NONE;
      LAY_TRIM96:       own = (s == 1 || s == 2) ? OWN_RAM : OWN_NONE;
      LAY_ROMC8_RAM128: own = (s == 1) ? OWN_ROM : ((s >= 2) ? OWN_RAM : OWN_NONE);
      LAY_ROMC0_RAM96:  own = (s == 0) ? OWN_ROM : ((s <= 2) ? OWN_RAM : OWN_NONE);
      LAY_ROMC8_RAM64:  own = (s == 1) ? OWN_ROM : ((s == 2) ? OWN_RAM : OWN_NONE);
      default:          own = OWN_NONE;
    endcase
    return own;
  endfunction

endpackage

// File: rtl/isa_memdec_ctrl.sv
module isa_memdec_ctrl
  import isa_memdec_pkg::*;
#(
  parameter int ADDR_W = ISA_AW,
  parameter logic [ADDR_W-1:0] BASE_TOP = 'h60000
) (
  input  logic [ADDR_W-1:0] memAddr,
  input  logic              memrN,
  input  logic              memwN,
  input  logic              aen,
  input  logic              cfgUpperEn,
  input  logic [2:0]        cfgLayout,
  output dec_strobe_t       strb
);

  logic [SLOT_N-1:0] slotHit;
  logic [SLOT_N-1:0] slotRam;
  logic [SLOT_N-1:0] slotRom;
  logic baseHit;
  logic rdCyc;
  logic wrCyc;
  logic upperRam;
  logic upperRom;

  genvar g;
  generate
    for (g = 0; g < SLOT_N; g++) begin : gSlot
      localparam logic [ADDR_W-1:0] SB = slotBase(g);
      localparam int SS = slotSpan(g);
      assign slotHit[g] = (memAddr[ADDR_W-1:SS] == SB[ADDR_W-1:SS]);
      assign slotRam[g] = slotHit[g] & cfgUpperEn & (slotOwner(cfgLayout, g) == OWN_RAM);
      assign slotRom[g] = slotHit[g] & cfgUpperEn & (slotOwner(cfgLayout, g) == OWN_ROM);
    end
  endgenerate

  assign baseHit  = (memAddr < BASE_TOP);
  assign rdCyc    = ~aen & ~memrN;
  assign wrCyc    = ~aen & memrN & ~memwN;
  assign upperRam = |slotRam;
  assign upperRom = |slotRom;

  always_comb begin
    strb.rdCyc     = rdCyc;
    strb.wrCyc     = wrCyc;
    strb.ramSel    = (baseHit | upperRam) & (rdCyc | wrCyc);
    strb.romSel    = upperRom & rdCyc;
    // C and D pages sit at bit17 = 0 and move up; E page already has it set
    strb.flipBit17 = upperRam & (memAddr[ADDR_W-1 -: 3] == 3'b110);
  end

  always_comb begin
    AST_ROM_READ_ONLY: assert (!strb.romSel || (!memrN && !aen))
      else $error("rom select outside read"); // R10
    AST_SEL_EXCL: assert (!(strb.ramSel && strb.romSel))
      else $error("ram and rom both selected"); // R13
  end

endmodule

// File: rtl/isa_memdec_dp.sv
module isa_memdec_dp
  import isa_memdec_pkg::*;
#(
  parameter int ADDR_W  = ISA_AW,
  parameter int SRAM_AW = 19,
  parameter int ROM_AW  = 15,
  parameter logic [ADDR_W-1:0] BASE_TOP = 'h60000
) (
  input  logic [ADDR_W-1:0]  memAddr,
  input  dec_strobe_t        strb,
  output logic               sramCsN,
  output logic [SRAM_AW-1:0] sramAddr,
  output logic               sramOeN,
  output logic               sramWeN,
  output logic               romCsN,
  output logic [ROM_AW-1:0]  romAddr,
  output logic               xcvrEnN,
  output logic               xcvrToBus
);

  localparam int FLIP_BIT = SRAM_AW - 2;
  localparam logic [SRAM_AW-1:0] BASE_S = BASE_TOP[SRAM_AW-1:0];

  logic claim;

  always_comb begin
    sramAddr           = memAddr[SRAM_AW-1:0];
    sramAddr[FLIP_BIT] = memAddr[FLIP_BIT] ^ strb.flipBit17;
  end

  assign sramCsN   = ~strb.ramSel;
  assign sramOeN   = ~(strb.ramSel & strb.rdCyc);
  assign sramWeN   = ~(strb.ramSel & strb.wrCyc);
  assign romCsN    = ~strb.romSel;
  assign romAddr   = memAddr[ROM_AW-1:0];
  assign claim     = strb.ramSel | strb.romSel;
  assign xcvrEnN   = ~claim;
  assign xcvrToBus = claim & strb.rdCyc;

  always_comb begin
    AST_OE_WE_EXCL: assert (sramOeN || sramWeN)
      else $error("oe and we together"); // R11
    AST_DIR_NEEDS_EN: assert (!xcvrToBus || !xcvrEnN)
      else $error("direction without enable"); // R12
    AST_ONE_DEVICE: assert (sramCsN || romCsN)
      else $error("two devices selected"); // R10
    AST_UPPER_NO_ALIAS: assert (sramCsN || memAddr < BASE_TOP || sramAddr >= BASE_S)
      else $error("upper window aliases base"); // R13
  end

endmodule

// File: rtl/isa_memdec_top.sv
module isa_memdec_top
  import isa_memdec_pkg::*;
#(
  parameter int ADDR_W  = ISA_AW,
  parameter int SRAM_AW = 19,
  parameter int ROM_AW  = 15,
  parameter logic [ADDR_W-1:0] BASE_TOP = 'h60000
) (
  input  logic [ADDR_W-1:0]  memAddr,
  input  logic               memrN,
  input  logic               memwN,
  input  logic               aen,
  input  logic               cfgUpperEn,
  input  logic [2:0]         cfgLayout,
  output logic               sramCsN,
  output logic [SRAM_AW-1:0] sramAddr,
  output logic               sramOeN,
  output logic               sramWeN,
  output logic               romCsN,
  output logic [ROM_AW-1:0]  romAddr,
  output logic               xcvrEnN,
  output logic               xcvrToBus
);

  dec_strobe_t strb;

  isa_memdec_ctrl #(.ADDR_W(ADDR_W), .BASE_TOP(BASE_TOP)) u_ctrl (
    .memAddr    (memAddr),
    .memrN      (memrN),
    .memwN      (memwN),
    .aen        (aen),
    .cfgUpperEn (cfgUpperEn),
    .cfgLayout  (cfgLayout),
    .strb       (strb)
  );

  isa_memdec_dp #(
    .ADDR_W(ADDR_W), .SRAM_AW(SRAM_AW), .ROM_AW(ROM_AW), .BASE_TOP(BASE_TOP)
  ) u_dp (
    .memAddr   (memAddr),
    .strb      (strb),
    .sramCsN   (sramCsN),
    .sramAddr  (sramAddr),
    .sramOeN   (sramOeN),
    .sramWeN   (sramWeN),
    .romCsN    (romCsN),
    .romAddr   (romAddr),
    .xcvrEnN   (xcvrEnN),
    .xcvrToBus (xcvrToBus)
  );

  always_comb begin
    AST_IDLE_QUIET: assert (!(aen || (memrN && memwN)) ||
                            (sramCsN && romCsN && xcvrEnN && !xcvrToBus))
      else $error("unclaimed cycle drives outputs"); // R9
  end

endmodule

// File: tb/isa_memdec_top_bench.sv
module isa_memdec_top_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  logic [19:0] memAddr = '0;
  logic memrN = 1'b1, memwN = 1'b1, aen = 1'b0;
  logic cfgUpperEn = 1'b0;
  logic [2:0] cfgLayout = '0;
  logic sramCsN, sramOeN, sramWeN, romCsN, xcvrEnN, xcvrToBus;
  logic [18:0] sramAddr;
  logic [14:0] romAddr;

  isa_memdec_top u_isa_memdec_top (
    .memAddr(memAddr), .memrN(memrN), .memwN(memwN), .aen(aen),
    .cfgUpperEn(cfgUpperEn), .cfgLayout(cfgLayout),
    .sramCsN(sramCsN), .sramAddr(sramAddr), .sramOeN(sramOeN), .sramWeN(sramWeN),
    .romCsN(romCsN), .romAddr(romAddr), .xcvrEnN(xcvrEnN), .xcvrToBus(xcvrToBus)
  );

  int nChecks = 0;
  int nErr = 0;
  bit finished = 1'b0;
  int owner[int];   // SRAM 8 KB granule -> bus 8 KB granule

  task automatic chk(input string tag, input string name, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s %s actual=%h expected=%h addr=%h en=%0d lay=%0d",
               tag, name, act, exp, memAddr, cfgUpperEn, cfgLayout);
    end
  endtask

  // behavioural reference for the current inputs, compared at the ports
  task automatic compareModel();
    int a = int'(memAddr);
    bit rdc = !aen && !memrN;
    bit wrc = !aen && memrN && !memwN;
    bit ram = 0, rom = 0, claimed;
    int sa = a;
    string rt;
    if (a < 'h60000) begin
      ram = 1; rt = "R1";
    end else if (a < 'hC0000 || a >= 'hF0000) begin
      rt = "R2";
    end else if (!cfgUpperEn || cfgLayout > 4) begin
      rt = "R8";
    end else begin
      case (cfgLayout)
        0: begin rt = "R3"; if (a < 'hE0000) begin ram = 1; sa = a - 'h60000; end end
        1: begin rt = "R4"; if (a >= 'hC8000 && a < 'hE0000) begin ram = 1; sa = a - 'h60000; end end
        2: begin
          rt = "R5";
          if (a >= 'hC8000 && a < 'hD0000) rom = 1;
          else if (a >= 'hD0000 && a < 'hE0000) begin ram = 1; sa = a - 'h60000; end
          else if (a >= 'hE0000) begin ram = 1; sa = a - 'h80000; end
        end
        3: begin
          rt = "R6";
          if (a < 'hC8000) rom = 1;
          else if (a < 'hE0000) begin ram = 1; sa = a - 'h60000; end
        end
        default: begin
          rt = "R7";
          if (a >= 'hC8000 && a < 'hD0000) rom = 1;
          else if (a >= 'hD0000 && a < 'hE0000) begin ram = 1; sa = a - 'h60000; end
        end
      endcase
    end
    if (!(rdc || wrc)) rt = "R9";
    claimed = (ram && (rdc || wrc)) || (rom && rdc);
    chk(rt, "sramCsN", int'(sramCsN), int'(!(ram && (rdc || wrc))));
    if (ram && (rdc || wrc)) begin
      chk(rt, "sramAddr", int'(sramAddr), sa);
      // R13: ownership of SRAM granules must be unique per strap setting
      if (owner.exists(int'(sramAddr) >> 13))
        chk("R13", "alias", owner[int'(sramAddr) >> 13], a >> 13);
      else
        owner[int'(sramAddr) >> 13] = a >> 13;
    end
    chk((rdc || wrc) ? "R10" : "R9", "romCsN", int'(romCsN), int'(!(rom && rdc)));
    if (rom && rdc) chk("R10", "romAddr", int'(romAddr), a & 'h7FFF);
    chk((rdc || wrc) ? "R11" : "R9", "sramOeN", int'(sramOeN), int'(!(ram && rdc)));
    chk((rdc || wrc) ? "R11" : "R9", "sramWeN", int'(sramWeN), int'(!(ram && wrc)));
    chk((rdc || wrc) ? "R12" : "R9", "xcvrEnN", int'(xcvrEnN), int'(!claimed));
    chk((rdc || wrc) ? "R12" : "R9", "xcvrToBus", int'(xcvrToBus), int'(claimed && rdc));
  endtask

  task automatic drive(input int a, input int mode);
    @(posedge clk);
    memAddr = 20'(a);
    case (mode)
      0: begin memrN = 0; memwN = 1; aen = 0; end   // read
      1: begin memrN = 1; memwN = 0; aen = 0; end   // write
      2: begin memrN = 0; memwN = 0; aen = 0; end   // both strobes
      3: begin memrN = 1; memwN = 1; aen = 0; end   // idle
      default: begin memrN = 0; memwN = 1; aen = 1; end  // DMA cycle
    endcase
    @(negedge clk);
    compareModel();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    nErr++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // reset-state check: idle bus, nothing claimed (R9)
    @(negedge clk);
    chk("R9", "idle sramCsN", int'(sramCsN), 1);
    chk("R9", "idle romCsN", int'(romCsN), 1);
    chk("R9", "idle xcvrEnN", int'(xcvrEnN), 1);
    for (int en = 0; en < 2; en++) begin
      for (int lay = 0; lay < 8; lay++) begin
        @(posedge clk);
        cfgUpperEn = en[0];
        cfgLayout = 3'(lay);
        owner.delete();
        for (int step = 0; step < 128; step++) begin
          for (int k = 0; k < 3; k++) begin
            int off = (k == 0) ? 0 : ((k == 1) ? 'h1FFF : int'($urandom & 'h1FFF));
            for (int mode = 0; mode < 5; mode++) drive((step << 13) + off, mode);
          end
        end
      end
    end
    // explicit 32 KB boundary of the C page, layout code 3 (R6) and code 2 (R5)
    @(posedge clk); cfgUpperEn = 1; cfgLayout = 3; owner.delete();
    drive('hC7FFF, 0); chk("R6", "C7FFF rom", int'(romCsN), 0);
    drive('hC8000, 0); chk("R6", "C8000 ram", int'(sramAddr), 'h68000);
    @(posedge clk); cfgLayout = 2; owner.delete();
    drive('hE0000, 1); chk("R5", "E0000 slice", int'(sramAddr), 'h60000);
    drive('hCC000, 1); chk("R10", "rom write ignored", int'(xcvrEnN), 1);
    summary();
  end

endmodule